// File: doc/BRIEF.md
# Priority Packet Retransmission Controller

This block gives reliable, in-order delivery of priority packets over a link that may corrupt or lose them. Its sending half takes packets from the user, stores each one in a slot of a small ring of packet buffers, labels it with a 3-bit sequence number and transmits it. A slot is released only when the far end acknowledges that packet. A negative acknowledgement, or a programmable period with no acknowledgement at all, makes the sender go back to the oldest unacknowledged packet and send it and every later stored packet again, in order.

The receiving half looks at each arriving packet together with an error flag that an external integrity checker supplies. A clean packet carrying the expected sequence number goes to the user and is answered with an ACK. The first corrupted or out-of-order packet is answered with one NACK. After that, the receiver drops everything silently until the expected packet arrives clean. In a system, one instance sits at each end. The sending half of one instance feeds the receiving half of the other, and the acknowledgement outputs of one feed the acknowledgement inputs of the other. Each packet is carried as one word of `DATA_W` bits.

Top module: `prio_retry_link`

## Requirements
- R1: After reset, `in_ready` is 1, and `tx_valid`, `out_valid` and `ack_out_valid` are 0.
- R2: Packets are numbered in acceptance order. The first packet after reset carries `tx_seq` 0, and each later packet carries the previous number plus one, modulo `NBUF` (8 by default, 3 bits). On a clean link each packet is transmitted exactly once, in that order.
- R3: An arriving packet with `rx_bad` = 0 and `rx_seq` equal to the expected number appears on `out_valid`/`out_data` on the cycle after it arrives. On that same cycle, `ack_out_valid` = 1, `ack_out_nack` = 0 and `ack_out_seq` equals its number.
- R4: An arriving packet that has `rx_bad` = 1 or carries an unexpected number, while no NACK is pending, gives `ack_out_valid` = 1 and `ack_out_nack` = 1 on the next cycle. `ack_out_seq` then holds the expected number, and nothing is delivered.
- R5: Once a NACK has been sent, every arriving packet is dropped without any response until the expected packet arrives clean. There is never a second NACK for the same failure.
- R6: A NACK whose `ack_in_seq` names the oldest unacknowledged packet makes the sender transmit that packet on the next cycle. The later stored packets then follow again, in order.
- R7: If packets are outstanding and no ACK or NACK for the oldest one arrives for `to_limit` cycles, the sender retransmits from the oldest one, as in R6. A `to_limit` that is lowered below the time already elapsed fires at once.
- R8: At most `NBUF` packets are outstanding. `in_ready` is 0 while `NBUF` packets await acknowledgement, and no packet is transmitted twice before an ACK, a NACK or a timeout.
- R9: An ACK for the oldest outstanding packet frees its slot. Every accepted packet is delivered exactly once and in order, whatever corruption or loss R4 to R7 recover from. Once all packets are acknowledged, `in_ready` is 1 and `tx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| to_limit | input | TO_W | Retransmit timeout in cycles |
| in_valid | input | 1 | User offers a packet |
| in_data | input | DATA_W | Offered packet |
| in_ready | output | 1 | Sender can store a packet |
| tx_valid | output | 1 | Packet on the outgoing link |
| tx_seq | output | log2(NBUF) | Sequence number of the outgoing packet |
| tx_data | output | DATA_W | Outgoing packet |
| ack_in_valid | input | 1 | Response from far receiver present |
| ack_in_nack | input | 1 | 1 = NACK, 0 = ACK |
| ack_in_seq | input | log2(NBUF) | Sequence number the response refers to |
| rx_valid | input | 1 | Packet on the incoming link |
| rx_seq | input | log2(NBUF) | Sequence number of the incoming packet |
| rx_data | input | DATA_W | Incoming packet |
| rx_bad | input | 1 | Integrity checker flags the incoming packet |
| out_valid | output | 1 | Packet delivered to the user |
| out_data | output | DATA_W | Delivered packet |
| ack_out_valid | output | 1 | Response to the far sender present |
| ack_out_nack | output | 1 | 1 = NACK, 0 = ACK |
| ack_out_seq | output | log2(NBUF) | Sequence number of the response |

## Verification
The bench closes the link on itself and runs six patterns. A clean run of ten packets crosses the 3-bit wrap and shows numbering and delivery with no recovery involved. A single corrupted packet, and a missing packet in the middle of a burst, each must give exactly one NACK followed by a go-back resend. This tells the error-flag path apart from the sequence-mismatch path. A packet corrupted on both its first send and its resend must still give only one NACK, so that recovery can only come from the timer. Losing the last packet of a burst produces no NACK at all, so that case isolates the timeout. A run with the link held down fills all eight slots and shows the stall and the absence of early resends.

// File: rtl/prio_retry_pkg.sv
`timescale 1ns/1ps
package prio_retry_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_TAKE = 2'd1,
    RX_NACK = 2'd2,
    RX_DROP = 2'd3
  } rx_act_e;

  // Decision for one arriving packet: clean and expected -> take,
  // otherwise answer once, then stay silent until recovery.
  function automatic rx_act_e rx_classify(input logic vld, input logic bad,
                                          input logic hit, input logic muted);
    if (!vld)        return RX_IDLE;
    if (!bad && hit) return RX_TAKE;
    if (muted)       return RX_DROP;
    return RX_NACK;
  endfunction

endpackage

// File: rtl/rtx_timer.sv
`timescale 1ns/1ps
module rtx_timer #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            clear,
  input  logic [TO_W-1:0] limit,
  output logic            fire
);
  logic [TO_W-1:0] cnt_q;

  function automatic logic reached(input logic [TO_W-1:0] c, input logic [TO_W-1:0] l);
    return c >= l;
  endfunction

  assign fire = run && !clear && reached(cnt_q, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!run || clear || fire)  cnt_q <= '0;
    else if (cnt_q != '1)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtx_sender.sv
`timescale 1ns/1ps
module rtx_sender #(
  parameter int NBUF   = 8,
  parameter int DATA_W = 16,
  parameter int TO_W   = 16,
  localparam int IDX_W = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TO_W-1:0]   to_limit,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              tx_valid,
  output logic [IDX_W-1:0]  tx_seq,
  output logic [DATA_W-1:0] tx_data,
  input  logic              ack_valid,
  input  logic              ack_nack,
  input  logic [IDX_W-1:0]  ack_seq
);
  localparam int PTR_W = IDX_W + 1;
  localparam logic [PTR_W-1:0] FULL = PTR_W'(NBUF);

  logic [PTR_W-1:0]  base_q, snd_q, wr_q, snd_nxt;
  logic [DATA_W-1:0] slot_q [NBUF];
  logic outstanding, ack_hit, ack_ok, nack_ok, tmo_fire, rewind;

  function automatic logic [PTR_W-1:0] occ(input logic [PTR_W-1:0] hi, input logic [PTR_W-1:0] lo);
    return hi - lo;
  endfunction

  assign outstanding = occ(wr_q, base_q) != '0;
  assign in_ready    = occ(wr_q, base_q) != FULL;
  assign ack_hit     = ack_valid && outstanding && (ack_seq == base_q[IDX_W-1:0]);
  assign ack_ok      = ack_hit && !ack_nack;
  assign nack_ok     = ack_hit && ack_nack;
  assign rewind      = nack_ok || tmo_fire;

  assign tx_valid = snd_q != wr_q;
  assign tx_seq   = snd_q[IDX_W-1:0];
  assign tx_data  = slot_q[snd_q[IDX_W-1:0]];

  rtx_timer #(.TO_W(TO_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(outstanding), .clear(ack_hit),
    .limit(to_limit), .fire(tmo_fire)
  );

  always_comb begin
    snd_nxt = snd_q;
    if (rewind)        snd_nxt = base_q;
    else if (tx_valid) snd_nxt = snd_q + 1'b1;
    if (ack_ok && snd_nxt == base_q) snd_nxt = base_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      snd_q  <= '0;
      wr_q   <= '0;
    end else begin
      snd_q <= snd_nxt;
      if (ack_ok) base_q <= base_q + 1'b1;
      if (in_valid && in_ready) wr_q <= wr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) slot_q[wr_q[IDX_W-1:0]] <= in_data;
  end

  // R8
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ(wr_q, base_q) <= FULL);
  // R6
  nack_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_ok |=> (tx_valid && tx_seq == $past(base_q[IDX_W-1:0])));
  // R7
  tmo_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_fire |=> (tx_valid && tx_seq == $past(base_q[IDX_W-1:0])));
endmodule

// File: rtl/rtx_receiver.sv
`timescale 1ns/1ps
module rtx_receiver import prio_retry_pkg::*; #(
  parameter int NBUF   = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [IDX_W-1:0]  rx_seq,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_bad,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              ack_valid,
  output logic              ack_nack,
  output logic [IDX_W-1:0]  ack_seq
);
  logic [IDX_W-1:0] exp_q;
  logic             muted_q;
  rx_act_e          act;

  assign act = rx_classify(rx_valid, rx_bad, rx_seq == exp_q, muted_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q     <= '0;
      muted_q   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      ack_valid <= 1'b0;
      ack_nack  <= 1'b0;
      ack_seq   <= '0;
    end else begin
      out_valid <= act == RX_TAKE;
      ack_valid <= (act == RX_TAKE) || (act == RX_NACK);
      ack_nack  <= act == RX_NACK;
      ack_seq   <= exp_q;
      if (act == RX_TAKE) begin
        out_data <= rx_data;
        exp_q    <= exp_q + 1'b1;
        muted_q  <= 1'b0;
      end else if (act == RX_NACK) begin
        muted_q  <= 1'b1;
      end
    end
  end

  // Observation state for the checks below, kept apart from the datapath.
  logic             pend_q;
  logic [IDX_W-1:0] last_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      last_q <= '1;
    end else begin
      if (out_valid)                   pend_q <= 1'b0;
      else if (ack_valid && ack_nack)  pend_q <= 1'b1;
      if (out_valid) last_q <= ack_seq;
    end
  end

  // R5
  one_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_nack) |-> !pend_q);
  // R3
  in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ack_valid && !ack_nack && ack_seq == IDX_W'(last_q + 1'b1)));
endmodule

// File: rtl/prio_retry_link.sv
`timescale 1ns/1ps
module prio_retry_link #(
  parameter int NBUF   = 8,
  parameter int DATA_W = 16,
  parameter int TO_W   = 16,
  localparam int IDX_W = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TO_W-1:0]   to_limit,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              tx_valid,
  output logic [IDX_W-1:0]  tx_seq,
  output logic [DATA_W-1:0] tx_data,
  input  logic              ack_in_valid,
  input  logic              ack_in_nack,
  input  logic [IDX_W-1:0]  ack_in_seq,
  input  logic              rx_valid,
  input  logic [IDX_W-1:0]  rx_seq,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_bad,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              ack_out_valid,
  output logic              ack_out_nack,
  output logic [IDX_W-1:0]  ack_out_seq
);
  rtx_sender #(.NBUF(NBUF), .DATA_W(DATA_W), .TO_W(TO_W)) snd_i (
    .clk(clk), .rst_n(rst_n), .to_limit(to_limit),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .tx_valid(tx_valid), .tx_seq(tx_seq), .tx_data(tx_data),
    .ack_valid(ack_in_valid), .ack_nack(ack_in_nack), .ack_seq(ack_in_seq)
  );

  rtx_receiver #(.NBUF(NBUF), .DATA_W(DATA_W)) rcv_i (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_seq(rx_seq), .rx_data(rx_data), .rx_bad(rx_bad),
    .out_valid(out_valid), .out_data(out_data),
    .ack_valid(ack_out_valid), .ack_nack(ack_out_nack), .ack_seq(ack_out_seq)
  );
endmodule

// File: tb/prio_retry_link_tb_top.sv
`timescale 1ns/1ps
module prio_retry_link_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] to_limit = 16'd30;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready, tx_valid, out_valid, ack_out_valid, ack_out_nack;
  logic [2:0]  tx_seq, ack_out_seq;
  logic [15:0] tx_data, out_data;
  logic        rx_valid, rx_bad, bad_now, drop_now;
  logic        link_down = 1'b0;

  int n_chk = 0, n_err = 0;
  int tx_cnt = 0, bad_used = 0, drop_used = 0, bad_arm = 0, drop_arm = 0;
  logic [2:0] bad_seq = '0, drop_seq = '0;
  int pushed = 0, deliv_cnt = 0, nack_cnt = 0, tx_idx = 0;
  bit clean_phase = 0, rw_pend = 0;
  logic [2:0] rw_seq = '0;
  logic [15:0] sb_q [$];

  always #5 clk = ~clk;

  assign bad_now  = tx_valid && (tx_seq == bad_seq) && (bad_used < bad_arm);
  assign drop_now = tx_valid && (tx_seq == drop_seq) && (drop_used < drop_arm);
  assign rx_valid = tx_valid && !drop_now && !link_down;
  assign rx_bad   = bad_now;

  prio_retry_link dut_i (
    .clk(clk), .rst_n(rst_n), .to_limit(to_limit),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .tx_valid(tx_valid), .tx_seq(tx_seq), .tx_data(tx_data),
    .ack_in_valid(ack_out_valid), .ack_in_nack(ack_out_nack), .ack_in_seq(ack_out_seq),
    .rx_valid(rx_valid), .rx_seq(tx_seq), .rx_data(tx_data), .rx_bad(rx_bad),
    .out_valid(out_valid), .out_data(out_data),
    .ack_out_valid(ack_out_valid), .ack_out_nack(ack_out_nack), .ack_out_seq(ack_out_seq)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (tx_valid) tx_cnt <= tx_cnt + 1;
      if (bad_now)  bad_used <= bad_used + 1;
      if (drop_now) drop_used <= drop_used + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // Driver: offers one packet and records it as expected once accepted.
  task automatic push_pkt();
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'h1000 + 16'(pushed);
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    sb_q.push_back(in_data);
    pushed++;
    #1 in_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int w = 0; w < 600 && sb_q.size() != 0; w++) @(negedge clk);
    chk(sb_q.size() == 0, tag, sb_q.size(), 0);
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b1 && tx_valid == 1'b0, "R9 all acked, slots free", {in_ready, tx_valid}, 2);
  endtask

  // Monitor: compares deliveries against the scoreboard and watches responses.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rw_pend) begin
        chk(tx_valid && tx_seq == rw_seq, "R6 resend oldest after NACK", tx_seq, rw_seq);
        rw_pend = 0;
      end
      if (clean_phase && tx_valid) begin
        chk(tx_seq == 3'(tx_idx), "R2 sequence number", tx_seq, 3'(tx_idx));
        tx_idx++;
      end
      if (out_valid) begin
        chk(ack_out_valid && !ack_out_nack && ack_out_seq == 3'(deliv_cnt),
            "R3 ACK with delivery", ack_out_seq, 3'(deliv_cnt));
        if (sb_q.size() == 0) chk(1'b0, "R9 unexpected delivery", out_data, 0);
        else begin
          logic [15:0] e;
          e = sb_q.pop_front();
          chk(out_data == e, "R9 delivery order", out_data, e);
        end
        deliv_cnt++;
      end
      if (ack_out_valid && ack_out_nack) begin
        nack_cnt++;
        chk(!out_valid && ack_out_seq == 3'(deliv_cnt), "R4 NACK carries expected seq",
            ack_out_seq, 3'(deliv_cnt));
        rw_pend = 1;
        rw_seq  = ack_out_seq;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    int n0, t0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(ack_out_valid == 1'b0, "R1 ack_out_valid", ack_out_valid, 0);
    rst_n = 1'b1;

    // R2 R3: clean run across the sequence wrap
    clean_phase = 1;
    n0 = nack_cnt;
    for (int i = 0; i < 10; i++) push_pkt();
    drain("R3 clean run delivered");
    clean_phase = 0;
    chk(nack_cnt == n0, "R3 no NACK on clean link", nack_cnt - n0, 0);
    chk(tx_idx == 10, "R2 each packet sent once", tx_idx, 10);

    // R4 R6: one corrupted packet
    n0 = nack_cnt;
    bad_seq = 3'(pushed + 1);
    bad_arm = bad_used + 1;
    for (int i = 0; i < 6; i++) push_pkt();
    drain("R6 recovered after corruption");
    chk(nack_cnt - n0 == 1, "R4 one NACK for corruption", nack_cnt - n0, 1);

    // R5 R7: packet corrupted on first send and on resend
    n0 = nack_cnt;
    bad_seq = 3'(pushed + 1);
    bad_arm = bad_used + 2;
    for (int i = 0; i < 6; i++) push_pkt();
    drain("R7 recovered by timeout after muted resend");
    chk(nack_cnt - n0 == 1, "R5 single NACK per failure", nack_cnt - n0, 1);

    // R4: lost packet in the middle, next one is out of order
    n0 = nack_cnt;
    drop_seq = 3'(pushed + 2);
    drop_arm = drop_used + 1;
    for (int i = 0; i < 5; i++) push_pkt();
    drain("R4 recovered after out-of-order");
    chk(nack_cnt - n0 == 1, "R4 one NACK for out-of-order", nack_cnt - n0, 1);

    // R7: last packet of burst lost, only the timer can recover
    n0 = nack_cnt;
    drop_seq = 3'(pushed + 2);
    drop_arm = drop_used + 1;
    for (int i = 0; i < 3; i++) push_pkt();
    drain("R7 timeout resend of lost tail");
    chk(nack_cnt - n0 == 0, "R7 no NACK for lost tail", nack_cnt - n0, 0);

    // R8: link down, all slots fill, no early resend
    to_limit = 16'hFFFF;
    link_down = 1'b1;
    t0 = tx_cnt;
    for (int i = 0; i < 8; i++) push_pkt();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R8 stall with all slots outstanding", in_ready, 0);
    end
    chk(tx_cnt - t0 == 8, "R8 no resend before timeout", tx_cnt - t0, 8);
    n0 = nack_cnt;
    to_limit = 16'd30;
    link_down = 1'b0;
    push_pkt();
    drain("R7 lowered limit fires and recovers");
    chk(nack_cnt - n0 == 0, "R7 recovery without NACK", nack_cnt - n0, 0);
    chk(deliv_cnt == pushed, "R9 every packet delivered once", deliv_cnt, pushed);

    finish_run();
  end
endmodule